// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps time of day and calendar date as a chain of packed-BCD counters. A one-cycle enable, pulsed at 32.768 kHz, drives a fractional prescaler that produces exactly one hundred sub-second steps per 32768 enables. Each step advances the hundredths field. From there, carries ripple through seconds, minutes, hours (24-hour form), day of week, day of month, month and year. A century flag flips each time the year wraps.

A host loads any field through a byte-wide write port addressed by a 3-bit index. It reads any field back through a combinational read port on the same index. The register index order is fixed: 0 hundredths (tenths in the upper digit), 1 seconds, 2 minutes, 3 century and hours, 4 day of week, 5 date, 6 month, 7 year. Month lengths and February in leap years are handled inside the block. Leap years are found with a divisible-by-four test on the two-digit year.

Top module: `bcd_calendar_top`

## Requirements
- R1: After synchronous reset, the registers at indices 0 to 7 read 00, 00, 00, 00, 01, 01, 01, 00 (hex).
- R2: When no enable and no write arrive, every field holds its value.
- R3: Counting starts from a cleared prescaler. The first hundredths step occurs on the 328th enable. Steps are spaced 327 or 328 enables apart, and exactly 32768 enables advance seconds by one with hundredths back at 00.
- R4: Hundredths count 00 to 99 in BCD and wrap to 00 while incrementing seconds. Seconds and minutes count 00 to 59 and each wraps to 00, carrying into the next field.
- R5: Hours count 00 to 23. The wrap from 23 to 00 advances day of week and date.
- R6: Day of week counts 1 to 7 and wraps from 7 to 1.
- R7: Date wraps to 01 and month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in every other month except 02.
- R8: February ends after day 29 when the BCD year is divisible by four (00, 12, 24, 96), and after day 28 otherwise (10, 23).
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and inverts the century flag.
- R10: Index 3 reads the century flag in bit 7, 0 in bit 6, and the BCD hours in bits 5:0. Day of week occupies bits 2:0 of index 4, with the upper bits reading 0.
- R11: A write loads its field on the next clock edge without disturbing any other field. A write to seconds also clears the prescaler, so the next hundredths step comes 328 enables later.
- R12: A full rollover from 23:59:59.99 on the last day of a year updates every field on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Field index written |
| wr_data | input | 8 | Packed BCD write value |
| rd_addr | input | 3 | Field index read |
| rd_data | output | 8 | Packed BCD value of the indexed field |

## Verification
The prescaler is run for one full second of enables, which separates a 327/328 alternating divider from any fixed-period divider. The field rollovers are tried by loading the time just before a carry and supplying one step. Month ends are tried on 30- and 31-day months and on February in years whose tens digit is odd or even. These cases expose a mistaken leap test or a swapped month length. A seconds write in the middle of a step interval shows whether the prescaler is cleared. The year-99 case on December 31 shows whether all fields and the century flag change on one edge.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

    typedef enum logic [2:0] {
        IDX_HUND  = 3'd0,
        IDX_SEC   = 3'd1,
        IDX_MIN   = 3'd2,
        IDX_HOUR  = 3'd3,
        IDX_WDAY  = 3'd4,
        IDX_DATE  = 3'd5,
        IDX_MONTH = 3'd6,
        IDX_YEAR  = 3'd7
    } field_idx_e;

    localparam int NUM_FIELDS = 8;

    typedef struct packed {
        logic [7:0] hund;
        logic [7:0] sec;
        logic [7:0] min;
        logic [5:0] hour;
    } tod_t;

    typedef struct packed {
        logic       cent;
        logic [2:0] wday;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } cal_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] top,
                                            input logic [7:0] bottom);
        if (v >= top)
            return bottom;
        else
            return bcd_inc(v);
    endfunction

    // Divisible by four on a two-digit BCD value: an even tens digit needs
    // units 0/4/8, an odd tens digit needs units 2/6.
    function automatic logic year_is_leap(input logic [7:0] yr);
        if (yr[4] == 1'b0)
            return (yr[1:0] == 2'b00);
        else
            return (yr[1:0] == 2'b10);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] yr);
        case (mon)
            8'h02:   return year_is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default: return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_subsec_prescaler.sv
module bcd_subsec_prescaler #(
    parameter int TICK_HZ       = 32768,
    parameter int STEPS_PER_SEC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clear,
    output logic step
);
    localparam int ACC_W = $clog2(TICK_HZ + STEPS_PER_SEC) + 1;
    localparam logic [ACC_W-1:0] INC = ACC_W'(STEPS_PER_SEC);
    localparam logic [ACC_W-1:0] MOD = ACC_W'(TICK_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;

    always_comb begin
        acc_sum = acc_q + INC;
        step    = tick && !clear && (acc_sum >= MOD);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc_q <= '0;
        else if (tick)
            acc_q <= (acc_sum >= MOD) ? (acc_sum - MOD) : acc_sum;
    end
endmodule

// File: rtl/bcd_tod_chain.sv
module bcd_tod_chain
    import bcd_calendar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step,
    input  logic [NUM_FIELDS-1:0] wr_sel,
    input  logic [7:0]            wr_data,
    output tod_t                  tod,
    output logic                  day_carry
);
    tod_t tod_q, tod_d;
    logic hund_wrap, sec_wrap, min_wrap;

    always_comb begin
        hund_wrap = step && (tod_q.hund >= 8'h99);
        sec_wrap  = hund_wrap && (tod_q.sec >= 8'h59);
        min_wrap  = sec_wrap && (tod_q.min >= 8'h59);
        day_carry = min_wrap && ({2'b00, tod_q.hour} >= 8'h23);

        tod_d = tod_q;
        if (step)      tod_d.hund = bcd_step(tod_q.hund, 8'h99, 8'h00);
        if (hund_wrap) tod_d.sec  = bcd_step(tod_q.sec, 8'h59, 8'h00);
        if (sec_wrap)  tod_d.min  = bcd_step(tod_q.min, 8'h59, 8'h00);
        if (min_wrap)  tod_d.hour = bcd_step({2'b00, tod_q.hour}, 8'h23, 8'h00)
                                    [5:0];

        if (wr_sel[IDX_HUND]) tod_d.hund = wr_data;
        if (wr_sel[IDX_SEC])  tod_d.sec  = wr_data;
        if (wr_sel[IDX_MIN])  tod_d.min  = wr_data;
        if (wr_sel[IDX_HOUR]) tod_d.hour = wr_data[5:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            tod_q <= '{hund: 8'h00, sec: 8'h00, min: 8'h00, hour: 6'h00};
        else
            tod_q <= tod_d;
    end

    assign tod = tod_q;
endmodule

// File: rtl/bcd_cal_chain.sv
module bcd_cal_chain
    import bcd_calendar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  day_carry,
    input  logic [NUM_FIELDS-1:0] wr_sel,
    input  logic [7:0]            wr_data,
    output cal_t                  cal
);
    cal_t       cal_q, cal_d;
    logic [7:0] last_day;
    logic       date_wrap, mon_wrap, year_wrap;

    always_comb begin
        last_day  = month_last_day(cal_q.month, cal_q.year);
        date_wrap = day_carry && (cal_q.date >= last_day);
        mon_wrap  = date_wrap && (cal_q.month >= 8'h12);
        year_wrap = mon_wrap && (cal_q.year >= 8'h99);

        cal_d = cal_q;
        if (day_carry) begin
            cal_d.wday = (cal_q.wday >= 3'd7) ? 3'd1 : cal_q.wday + 3'd1;
            cal_d.date = bcd_step(cal_q.date, last_day, 8'h01);
        end
        if (date_wrap) cal_d.month = bcd_step(cal_q.month, 8'h12, 8'h01);
        if (mon_wrap)  cal_d.year  = bcd_step(cal_q.year, 8'h99, 8'h00);
        if (year_wrap) cal_d.cent  = !cal_q.cent;

        if (wr_sel[IDX_HOUR])  cal_d.cent  = wr_data[7];
        if (wr_sel[IDX_WDAY])  cal_d.wday  = wr_data[2:0];
        if (wr_sel[IDX_DATE])  cal_d.date  = wr_data;
        if (wr_sel[IDX_MONTH]) cal_d.month = wr_data;
        if (wr_sel[IDX_YEAR])  cal_d.year  = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cal_q <= '{cent: 1'b0, wday: 3'd1, date: 8'h01,
                       month: 8'h01, year: 8'h00};
        else
            cal_q <= cal_d;
    end

    assign cal = cal_q;
endmodule

// File: rtl/bcd_calendar_top.sv
module bcd_calendar_top
    import bcd_calendar_pkg::*;
#(
    parameter int TICK_HZ       = 32768,
    parameter int STEPS_PER_SEC = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_32k,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    logic [NUM_FIELDS-1:0] wr_sel;
    logic                  hund_step;
    logic                  day_carry;
    tod_t                  tod;
    cal_t                  cal;
    logic [7:0]            field_bytes [NUM_FIELDS];

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_wdec
        assign wr_sel[gi] = wr_en && (wr_addr == 3'(gi));
    end

    bcd_subsec_prescaler #(
        .TICK_HZ      (TICK_HZ),
        .STEPS_PER_SEC(STEPS_PER_SEC)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_32k),
        .clear(wr_sel[IDX_SEC]),
        .step (hund_step)
    );

    bcd_tod_chain u_tod (
        .clk      (clk),
        .rst      (rst),
        .step     (hund_step),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tod      (tod),
        .day_carry(day_carry)
    );

    bcd_cal_chain u_cal (
        .clk      (clk),
        .rst      (rst),
        .day_carry(day_carry),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cal      (cal)
    );

    always_comb begin
        field_bytes[IDX_HUND]  = tod.hund;
        field_bytes[IDX_SEC]   = tod.sec;
        field_bytes[IDX_MIN]   = tod.min;
        field_bytes[IDX_HOUR]  = {cal.cent, 1'b0, tod.hour};
        field_bytes[IDX_WDAY]  = {5'b00000, cal.wday};
        field_bytes[IDX_DATE]  = cal.date;
        field_bytes[IDX_MONTH] = cal.month;
        field_bytes[IDX_YEAR]  = cal.year;
        rd_data = field_bytes[rd_addr];
    end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_32k,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic       step,
    input logic [7:0] hund,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [5:0] hour,
    input logic [7:0] year,
    input logic       cent
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_32k && !wr_en) |=> ($stable(hund) && $stable(sec) &&
                                   $stable(min) && $stable(hour) &&
                                   $stable(year) && $stable(cent)));

    // R3
    step_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> tick_32k);

    // R4
    hund_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && hund == 8'h99) |=> (hund == 8'h00 && sec != $past(sec)));

    // R5
    hour_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && hund == 8'h99 && sec == 8'h59 && min == 8'h59 &&
         hour == 6'h23) |=> (hour == 6'h00));

    // R9
    cent_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && cent != $past(cent)) |-> (year == 8'h00 && $past(year) == 8'h99));

    // R11
    sec_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd1) |=> $stable(hund));
endmodule

bind bcd_calendar_top bcd_calendar_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_32k(tick_32k),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .step    (hund_step),
    .hund    (tod.hund),
    .sec     (tod.sec),
    .min     (tod.min),
    .hour    (tod.hour),
    .year    (cal.year),
    .cent    (cal.cent)
);

// File: tb/test_bcd_calendar_top.sv
module test_bcd_calendar_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_32k = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bcd_calendar_top i_bcd_calendar_top (
        .clk(clk), .rst(rst), .tick_32k(tick_32k), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic expect_field(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_32k = 1'b1;
        repeat (n) @(negedge clk);
        tick_32k = 1'b0;
    endtask

    // Loads 23:59:59.99 with the given calendar and supplies one step.
    task automatic roll_day(input logic [7:0] hb, input logic [7:0] wd,
                            input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] yr);
        wr(3, hb); wr(2, 8'h59); wr(4, wd); wr(5, dt); wr(6, mo); wr(7, yr);
        wr(1, 8'h59);
        wr(0, 8'h99);
        run_ticks(328);
    endtask

    task automatic t_reset;
        expect_field("R1 hund", 0, 8'h00);
        expect_field("R1 sec", 1, 8'h00);
        expect_field("R1 min", 2, 8'h00);
        expect_field("R1 hour", 3, 8'h00);
        expect_field("R1 wday", 4, 8'h01);
        expect_field("R1 date", 5, 8'h01);
        expect_field("R1 month", 6, 8'h01);
        expect_field("R1 year", 7, 8'h00);
    endtask

    task automatic t_idle;
        repeat (50) @(negedge clk);
        expect_field("R2 hund idle", 0, 8'h00);
        expect_field("R2 sec idle", 1, 8'h00);
    endtask

    task automatic t_prescaler;
        run_ticks(327);
        expect_field("R3 before first step", 0, 8'h00);
        run_ticks(1);
        expect_field("R3 first step", 0, 8'h01);
        run_ticks(32768 - 328 - 1);
        expect_field("R3 one tick short", 0, 8'h99);
        expect_field("R3 sec not yet", 1, 8'h00);
        run_ticks(1);
        expect_field("R3 R4 hund wrap", 0, 8'h00);
        expect_field("R3 R4 sec carry", 1, 8'h01);
    endtask

    task automatic t_sec_write;
        run_ticks(200);
        wr(1, 8'h30);
        expect_field("R11 sec loaded", 1, 8'h30);
        expect_field("R11 hund untouched", 0, 8'h00);
        run_ticks(327);
        expect_field("R11 cleared prescaler", 0, 8'h00);
        run_ticks(1);
        expect_field("R11 step after clear", 0, 8'h01);
        wr(6, 8'h07);
        expect_field("R11 month loaded", 6, 8'h07);
        expect_field("R11 year untouched", 7, 8'h00);
        expect_field("R11 sec untouched", 1, 8'h30);
    endtask

    task automatic t_minute_carry;
        wr(2, 8'h41); wr(1, 8'h59); wr(0, 8'h99);
        run_ticks(328);
        expect_field("R4 min carry", 2, 8'h42);
        expect_field("R4 sec wrap", 1, 8'h00);
        wr(3, 8'h09); wr(2, 8'h59); wr(1, 8'h59); wr(0, 8'h99);
        run_ticks(328);
        expect_field("R4 hour carry 09->10", 3, 8'h10);
    endtask

    task automatic t_day_roll;
        roll_day(8'h23, 8'h07, 8'h15, 8'h06, 8'h20);
        expect_field("R5 hour wrap", 3, 8'h00);
        expect_field("R5 date advance", 5, 8'h16);
        expect_field("R6 wday 7->1", 4, 8'h01);
        roll_day(8'h23, 8'h03, 8'h16, 8'h06, 8'h20);
        expect_field("R6 wday 3->4", 4, 8'h04);
    endtask

    task automatic t_month_end(input string tag, input logic [7:0] dt,
                               input logic [7:0] mo, input logic [7:0] yr,
                               input logic [7:0] exp_dt, input logic [7:0] exp_mo);
        roll_day(8'h23, 8'h02, dt, mo, yr);
        expect_field({tag, " date"}, 5, exp_dt);
        expect_field({tag, " month"}, 6, exp_mo);
    endtask

    task automatic t_year_end;
        roll_day(8'h23, 8'h05, 8'h31, 8'h12, 8'h45);
        expect_field("R9 month wrap", 6, 8'h01);
        expect_field("R9 year advance", 7, 8'h46);
        expect_field("R9 century kept", 3, 8'h00);
        roll_day(8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        expect_field("R12 hund", 0, 8'h00);
        expect_field("R12 sec", 1, 8'h00);
        expect_field("R12 min", 2, 8'h00);
        expect_field("R12 R9 R10 century set", 3, 8'h80);
        expect_field("R12 wday", 4, 8'h06);
        expect_field("R12 date", 5, 8'h01);
        expect_field("R12 month", 6, 8'h01);
        expect_field("R12 R9 year wrap", 7, 8'h00);
        roll_day(8'hA3, 8'h01, 8'h31, 8'h12, 8'h99);
        expect_field("R9 century cleared", 3, 8'h00);
    endtask

    task automatic t_map;
        wr(3, 8'hD2);
        expect_field("R10 century and hours", 3, 8'h92);
        wr(4, 8'hFE);
        expect_field("R10 wday bits", 4, 8'h06);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_prescaler();
        t_sec_write();
        t_minute_carry();
        t_day_roll();
        t_month_end("R7 Apr 30", 8'h30, 8'h04, 8'h21, 8'h01, 8'h05);
        t_month_end("R7 Jan 30", 8'h30, 8'h01, 8'h21, 8'h31, 8'h01);
        t_month_end("R7 Jan 31", 8'h31, 8'h01, 8'h21, 8'h01, 8'h02);
        t_month_end("R7 Nov 30", 8'h30, 8'h11, 8'h21, 8'h01, 8'h12);
        t_month_end("R7 Sep 30", 8'h30, 8'h09, 8'h21, 8'h01, 8'h10);
        t_month_end("R8 Feb 28 y23", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
        t_month_end("R8 Feb 28 y24", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
        t_month_end("R8 Feb 29 y24", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
        t_month_end("R8 Feb 28 y00", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
        t_month_end("R8 Feb 28 y10", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
        t_month_end("R8 Feb 28 y12", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
        t_month_end("R8 Feb 28 y96", 8'h28, 8'h02, 8'h96, 8'h29, 8'h02);
        t_year_end();
        t_map();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule